// File: doc/BRIEF.md
# MSI to SPI Conversion Frame

This block is a small memory-mapped register frame that lets an interrupt controller without native message-signalled interrupt support accept MSIs. A bus master, typically a PCIe endpoint or an internal DMA engine, writes an interrupt ID to a doorbell register. If the ID belongs to the range the frame owns, the frame raises a one-cycle pulse on the matching shared peripheral interrupt (SPI) line toward the distributor. If the ID is outside that range, the frame pulses an error strobe and fires no line.

Software discovers the frame's range by reading a read-only type register. This register reports the first SPI number and the count of SPIs, each in a 10-bit field. An identification register reads as zero. The frame decodes a 4 KiB window through a plain 32-bit register bus with separate read and write enables. Read data comes back one cycle after the read.

The first SPI number and the count are build-time parameters. Elaboration stops with an error in three cases: the first SPI is below 32, the count is zero, or the range runs past ID 1019.

Top module: `msi_spi_frame`

## Requirements
- R1: A read of byte offset 0x008 returns, in the cycle after the read, the word `(BASE_SPI << 16) | NUM_SPIS`. Bits 25:16 hold the first SPI number, bits 9:0 hold the count, and all other bits are zero.
- R2: A read of byte offset 0xFCC (identification) returns zero in the cycle after the read.
- R3: A read of the doorbell offset 0x040 or of any unimplemented offset returns zero in the cycle after the read. `rdata` is also zero in the cycle after any cycle with `rd_en` low.
- R4: A write to offset 0x040 whose interrupt ID is in `[BASE_SPI, BASE_SPI+NUM_SPIS)` drives bit `ID-BASE_SPI` of `spi_pulse` high for exactly the one cycle after the write. All other bits stay low and `err_pulse` stays low.
- R5: The interrupt ID is bits 9:0 of `wdata`. Bits 31:10 have no effect.
- R6: A doorbell write with an ID below `BASE_SPI` pulses `err_pulse` for the one cycle after the write and fires no SPI line.
- R7: A doorbell write with an ID at or above `BASE_SPI+NUM_SPIS` pulses `err_pulse` for the one cycle after the write and fires no SPI line.
- R8: A write to any offset other than 0x040 produces no SPI pulse, no error pulse, and no change to the value read from the type register.
- R9: Doorbell writes in consecutive cycles produce their pulses or errors in consecutive cycles, with none merged or lost.
- R10: While `rst` is high, `spi_pulse`, `err_pulse` and `rdata` are zero after each clock edge, even if a doorbell write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset within the 4 KiB frame |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| spi_pulse | output | NUM_SPIS | One-cycle pulse per owned SPI line |
| err_pulse | output | 1 | One-cycle pulse on a rejected doorbell ID |

## Verification
The bench builds the frame with `BASE_SPI = 1000` and `NUM_SPIS = 20`. With this range, the last owned line is ID 1019, the highest legal SPI, so the upper-edge acceptance of 1019 and the rejection of 1020 and 1023 both fall inside the 10-bit ID space. A base far from zero makes any error in the base subtraction or field packing visible. The count of 20 is not a power of two, so the line-index width and the range compare cannot agree by accident.

// File: rtl/msf_pkg.sv
package msf_pkg;

  localparam int FRAME_BYTES = 4096;
  localparam int ADDR_W      = $clog2(FRAME_BYTES);
  localparam int DATA_W      = 32;
  localparam int ID_W        = 10;
  localparam int FIELD_SHIFT = 16;

  localparam int MIN_SPI_ID  = 32;
  localparam int SPI_ID_END  = 1020;

  localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;

  localparam logic [DATA_W-1:0] IDENT_VALUE  = '0;

  function automatic logic [DATA_W-1:0] type_word(input int base, input int num);
    logic [ID_W-1:0] b;
    logic [ID_W-1:0] n;
    b = ID_W'(base);
    n = ID_W'(num);
    return (DATA_W'(b) << FIELD_SHIFT) | DATA_W'(n);
  endfunction

  function automatic logic in_window(input logic [ID_W-1:0] id, input int base, input int num);
    return (int'(id) >= base) && (int'(id) < base + num);
  endfunction

  function automatic int line_of(input logic [ID_W-1:0] id, input int base);
    return int'(id) - base;
  endfunction

endpackage

// File: rtl/msf_decode.sv
module msf_decode
  import msf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              db_wr,
  output logic              type_rd,
  output logic              ident_rd
);

  logic hit_db;
  logic hit_type;
  logic hit_ident;

  always_comb begin
    hit_db    = (addr == OFS_DOORBELL);
    hit_type  = (addr == OFS_TYPE);
    hit_ident = (addr == OFS_IDENT);
  end

  assign db_wr    = wr_en && hit_db;
  assign type_rd  = rd_en && hit_type;
  assign ident_rd = rd_en && hit_ident;

endmodule

// File: rtl/msf_doorbell.sv
module msf_doorbell
  import msf_pkg::*;
#(
  parameter int BASE_SPI = 32,
  parameter int NUM_SPIS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                db_wr,
  input  logic [ID_W-1:0]     id,
  output logic [NUM_SPIS-1:0] spi_pulse,
  output logic                err_pulse,
  output logic                id_ok_w,
  output logic                fire_w
);

  localparam int IDX_W = (NUM_SPIS > 1) ? $clog2(NUM_SPIS) : 1;

  logic [IDX_W-1:0] line_w;
  logic             reject_w;

  assign id_ok_w  = in_window(id, BASE_SPI, NUM_SPIS);
  assign line_w   = IDX_W'(line_of(id, BASE_SPI));
  assign fire_w   = db_wr && id_ok_w;
  assign reject_w = db_wr && !id_ok_w;

  for (genvar i = 0; i < NUM_SPIS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) spi_pulse[i] <= 1'b0;
      else     spi_pulse[i] <= fire_w && (line_w == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= reject_w;
  end

endmodule

// File: rtl/msf_readback.sv
module msf_readback
  import msf_pkg::*;
#(
  parameter int BASE_SPI = 32,
  parameter int NUM_SPIS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              type_rd,
  input  logic              ident_rd,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] TYPE_VAL = type_word(BASE_SPI, NUM_SPIS);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    if (type_rd)       rdata_d = TYPE_VAL;
    else if (ident_rd) rdata_d = IDENT_VALUE;
    else               rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_d;
  end

endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
  import msf_pkg::*;
#(
  parameter int BASE_SPI = 32,
  parameter int NUM_SPIS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [11:0]         addr,
  input  logic [31:0]         wdata,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [31:0]         rdata,
  output logic [NUM_SPIS-1:0] spi_pulse,
  output logic                err_pulse
);

  if (BASE_SPI < MIN_SPI_ID) begin : g_bad_base
    $error("msi_spi_frame: BASE_SPI below first shared ID");
  end
  if (NUM_SPIS < 1) begin : g_bad_count
    $error("msi_spi_frame: NUM_SPIS must be at least one");
  end
  if (BASE_SPI + NUM_SPIS > SPI_ID_END) begin : g_bad_range
    $error("msi_spi_frame: SPI range passes the last shared ID");
  end

  logic            db_wr_w;
  logic            type_rd_w;
  logic            ident_rd_w;
  logic            id_ok_w;
  logic            fire_w;
  logic [ID_W-1:0] id_w;
  logic            unused_wdata_hi;

  assign id_w            = wdata[ID_W-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:ID_W];

  msf_decode u_decode (
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .db_wr    (db_wr_w),
    .type_rd  (type_rd_w),
    .ident_rd (ident_rd_w)
  );

  msf_doorbell #(
    .BASE_SPI (BASE_SPI),
    .NUM_SPIS (NUM_SPIS)
  ) u_doorbell (
    .clk       (clk),
    .rst       (rst),
    .db_wr     (db_wr_w),
    .id        (id_w),
    .spi_pulse (spi_pulse),
    .err_pulse (err_pulse),
    .id_ok_w   (id_ok_w),
    .fire_w    (fire_w)
  );

  msf_readback #(
    .BASE_SPI (BASE_SPI),
    .NUM_SPIS (NUM_SPIS)
  ) u_readback (
    .clk      (clk),
    .rst      (rst),
    .type_rd  (type_rd_w),
    .ident_rd (ident_rd_w),
    .rdata    (rdata)
  );

endmodule

// File: rtl/msf_checker.sv
module msf_checker
  import msf_pkg::*;
#(
  parameter int BASE_SPI = 32,
  parameter int NUM_SPIS = 64
) (
  input logic                clk,
  input logic                rst,
  input logic [11:0]         addr,
  input logic [31:0]         wdata,
  input logic                wr_en,
  input logic                rd_en,
  input logic [31:0]         rdata,
  input logic [NUM_SPIS-1:0] spi_pulse,
  input logic                err_pulse,
  input logic                db_wr_w,
  input logic                ident_rd_w,
  input logic                fire_w
);

  logic [31:0] exp_type;
  logic        wr_db_port;
  logic        id_low;
  logic        id_high;
  logic        rst_seen;

  assign exp_type   = (32'(BASE_SPI) << 16) | 32'(NUM_SPIS);
  assign wr_db_port = wr_en && (addr == 12'h040);
  assign id_low     = int'(wdata[9:0]) < BASE_SPI;
  assign id_high    = int'(wdata[9:0]) >= BASE_SPI + NUM_SPIS;

  p_type_read_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 12'h008) |=> (rdata == exp_type));

  p_ident_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ident_rd_w |=> (rdata == 32'd0));

  p_rd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == 12'h008) |=> (rdata == 32'd0));

  p_one_line_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(spi_pulse));

  p_valid_fires_r4: assert property (@(posedge clk) disable iff (rst)
    fire_w |=> ($countones(spi_pulse) == 1 && !err_pulse));

  p_err_low_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_db_port && id_low) |=> (err_pulse && spi_pulse == '0));

  p_err_high_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_db_port && id_high) |=> (err_pulse && spi_pulse == '0));

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    !db_wr_w |=> (spi_pulse == '0 && !err_pulse));

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      p_reset_r10: assert (spi_pulse == '0 && !err_pulse && rdata == 32'd0);
    end
  end

endmodule

bind msi_spi_frame msf_checker #(
  .BASE_SPI (BASE_SPI),
  .NUM_SPIS (NUM_SPIS)
) u_msf_checker (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .wdata      (wdata),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .spi_pulse  (spi_pulse),
  .err_pulse  (err_pulse),
  .db_wr_w    (db_wr_w),
  .ident_rd_w (ident_rd_w),
  .fire_w     (fire_w)
);

// File: tb/tb_msi_spi_frame.sv
`timescale 1ns/1ps
module tb_msi_spi_frame;

  localparam int BASE = 1000;
  localparam int NUM  = 20;
  localparam logic [11:0] A_TYPE = 12'h008;
  localparam logic [11:0] A_DB   = 12'h040;
  localparam logic [11:0] A_ID   = 12'hFCC;
  localparam logic [31:0] TYPE_EXP = 32'(BASE * 65536 + NUM);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [31:0]     rdata;
  logic [NUM-1:0]  spi_pulse;
  logic            err_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  int             due_q[$];
  logic [NUM-1:0] spi_q[$];
  logic           err_q[$];
  logic [31:0]    rd_q[$];
  string          tag_q[$];

  msi_spi_frame #(.BASE_SPI(BASE), .NUM_SPIS(NUM)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .spi_pulse(spi_pulse), .err_pulse(err_pulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic drive(input logic we, input logic re, input logic [11:0] a,
                       input logic [31:0] wd, input string tag);
    int id;
    logic [NUM-1:0] es;
    logic ee;
    @(posedge clk);
    #2;
    wr_en = we; rd_en = re; addr = a; wdata = wd;
    id = int'(wd[9:0]);
    es = '0;
    ee = 1'b0;
    if (we && a == A_DB) begin
      if (id >= BASE && id < BASE + NUM) es[id - BASE] = 1'b1;
      else ee = 1'b1;
    end
    due_q.push_back(cyc + 1);
    spi_q.push_back(es);
    err_q.push_back(ee);
    rd_q.push_back((re && a == A_TYPE) ? TYPE_EXP : 32'd0);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 12'h000, 32'd0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [NUM-1:0] es;
        logic ee;
        logic [31:0] er;
        string t;
        void'(due_q.pop_front());
        es = spi_q.pop_front();
        ee = err_q.pop_front();
        er = rd_q.pop_front();
        t  = tag_q.pop_front();
        n_checks++;
        if (spi_pulse !== es || err_pulse !== ee || rdata !== er) begin
          n_fails++;
          $display("FAIL %s: spi=%h err=%b rdata=%h expected spi=%h err=%b rdata=%h",
                   t, spi_pulse, err_pulse, rdata, es, ee, er);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    n_fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin : stimulus
    // R10: doorbell presented while reset is high
    wr_en = 1'b1; addr = A_DB; wdata = 32'd1000; rd_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (spi_pulse !== '0 || err_pulse !== 1'b0 || rdata !== 32'd0) begin
      n_fails++;
      $display("FAIL R10 reset: spi=%h err=%b rdata=%h expected all zero",
               spi_pulse, err_pulse, rdata);
    end
    @(posedge clk);
    #2;
    rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;

    idle("R3 idle read");
    drive(1'b0, 1'b1, A_TYPE, 32'd0, "R1 type read");
    drive(1'b0, 1'b1, A_ID,   32'd0, "R2 ident read");
    drive(1'b0, 1'b1, A_DB,   32'd0, "R3 doorbell read");
    drive(1'b0, 1'b1, 12'h100, 32'd0, "R3 unimplemented read");
    drive(1'b0, 1'b1, 12'h00C, 32'd0, "R3 neighbour read");
    drive(1'b0, 1'b0, A_TYPE, 32'd0, "R3 rd_en low");

    drive(1'b1, 1'b0, A_DB, 32'd1000, "R4 first line");
    idle("R4 pulse one cycle");
    drive(1'b1, 1'b0, A_DB, 32'd1019, "R4 last line");
    idle("R4 pulse one cycle");
    drive(1'b1, 1'b0, A_DB, 32'd1007, "R4 mid line");
    idle("R4 pulse one cycle");

    drive(1'b1, 1'b0, A_DB, 32'hABCD_E000 | 32'd1005, "R5 upper bits ignored");
    drive(1'b1, 1'b0, A_DB, 32'h0000_0400 | 32'd1002, "R5 bit 10 ignored");
    idle("R5 after");

    drive(1'b1, 1'b0, A_DB, 32'd999, "R6 just below base");
    drive(1'b1, 1'b0, A_DB, 32'd0,   "R6 zero id");
    drive(1'b1, 1'b0, A_DB, 32'd32,  "R6 first shared id");
    idle("R6 after");

    drive(1'b1, 1'b0, A_DB, 32'd1020, "R7 one past top");
    drive(1'b1, 1'b0, A_DB, 32'd1023, "R7 max id");
    idle("R7 after");

    drive(1'b1, 1'b0, 12'h044, 32'd1005, "R8 write near doorbell");
    drive(1'b1, 1'b0, A_TYPE, 32'hFFFF_FFFF, "R8 write type reg");
    drive(1'b1, 1'b0, A_ID,   32'd1003, "R8 write ident reg");
    drive(1'b0, 1'b1, A_TYPE, 32'd0, "R8 type unchanged");

    drive(1'b1, 1'b0, A_DB, 32'd1001, "R9 back-to-back a");
    drive(1'b1, 1'b0, A_DB, 32'd1002, "R9 back-to-back b");
    drive(1'b1, 1'b0, A_DB, 32'd1030, "R9 back-to-back reject");
    drive(1'b1, 1'b0, A_DB, 32'd1001, "R9 back-to-back repeat");
    idle("R9 after");
    idle("R9 settle");

    repeat (3) @(posedge clk);
    if (due_q.size() != 0) begin
      n_fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", due_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule